// File: doc/BRIEF.md
# Lehmer-Gray Permutation Encoder

This block turns a block of signed sample values into response bits that describe only the relative order of the values, not their magnitude. A block of N values is loaded one value per handshake. The block then counts, for every position, how many later values are smaller. These counts are the digits of the Lehmer code. Each digit is converted to binary Gray code and queued. The queued digits leave the block as a serial bit stream.

Counting is sequential and uses a fixed amount of logic. A source index steps once through the positions. For each source, a target pointer sweeps the later entries M at a time. M comparators work in parallel, and a popcount adds their matches to a running count. When the last group for a source has been compared, the finished digit is pushed into a digit FIFO. A serializer drains that FIFO one bit per accepted output handshake.

Back-pressure rules:
- The load port accepts a value only while no count is running. A new block may be loaded as soon as the previous count has ended, even if its bits are still draining.
- The output holds a bit stable until it is taken.
- When the digit FIFO is full, the sequencer freezes on the finished digit until a slot frees.

Top module: `lehmer_gray_encoder`

## Requirements
- R1: `in_ready` is high exactly when no count is running. Values are stored in arrival order; the first value accepted is position 0. The clock edge that accepts the N-th value makes `busy` high on the next cycle, and `in_ready` then reads 0.
- R2: Digit i equals the number of positions j > i whose value is smaller than the value at i. Values are compared as two's-complement signed numbers, and an equal value is not counted.
- R3: Each digit d is emitted as the Gray code d ^ (d >> 1), most significant bit first, over ceil(log2(N - i)) bits. The digit of the last position is not emitted, so a block of N = 32 yields 129 bits.
- R4: Digits leave in increasing position order. Blocks leave in the order they were loaded.
- R5: With no output stall, `busy` stays high for exactly the sum over i = 0..N-2 of ceil((N-1-i)/M) cycles. This is 76 cycles for N = 32 and M = 8.
- R6: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_valid` hold. No bit is lost or repeated. A finished digit that meets a full FIFO freezes the sequencer, so `busy` stays high longer.
- R7: After reset, `in_ready` = 1, `busy` = 0 and `out_valid` = 0.
- R8: A block loaded while the previous block's bits are still queued is encoded correctly. Its bits follow the previous block's bits without gaps in content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A value is offered on `in_data` |
| in_ready | output | 1 | Block accepts a value (no count running) |
| in_data | input | W | Signed value to store |
| busy | output | 1 | Lehmer counting is in progress |
| out_valid | output | 1 | `out_bit` holds a response bit |
| out_ready | input | 1 | Consumer takes `out_bit` this cycle |
| out_bit | output | 1 | Serial Gray-coded response bit |

## Verification
Two events can fall in the same cycle, and the bench provokes both.

The first is a finished digit meeting a full digit FIFO while the serializer pops. The bench loads two blocks back to back with `out_ready` held low, so the second block's count runs into a full queue. It then checks that `busy` stays high well past the nominal count time. After `out_ready` is released, the combined stream of both blocks must match the bench's own Lehmer-Gray model bit for bit.

The second is a new block being loaded while the previous block's bits are still being serialized under an irregular ready pattern. Here too the stream must match the model, with each stalled bit held unchanged.

// File: rtl/lg_pkg.sv
package lg_pkg;
  // ceil(log2(v)) for v >= 1; 0 for v <= 1
  function automatic int bits_for(input int v);
    int r;
    r = 0;
    for (int k = 0; k < 31; k++) begin
      if ((1 << k) < v) r = k + 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lg_value_store.sv
module lg_value_store #(
  parameter int N  = 32,
  parameter int W  = 12,
  parameter int M  = 8,
  parameter int IW = 5,
  parameter int TW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic signed [W-1:0] wr_data,
  input  logic [IW-1:0]       src,
  input  logic [TW-1:0]       tgt,
  output logic                load_last,
  output logic signed [W-1:0] src_val,
  output logic signed [W-1:0] tgt_vals [M],
  output logic [M-1:0]        tgt_ok
);
  logic signed [W-1:0] vals_q [N];
  logic [IW-1:0]       wptr_q;

  assign load_last = wr_en && (wptr_q == IW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (wr_en) begin
      wptr_q <= load_last ? '0 : wptr_q + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) vals_q[wptr_q] <= wr_data;
  end

  assign src_val = vals_q[src];

  // window of M target entries starting at tgt
  always_comb begin
    for (int k = 0; k < M; k++) begin
      int idx;
      idx = int'(tgt) + k;
      if (idx < N) begin
        tgt_ok[k]   = 1'b1;
        tgt_vals[k] = vals_q[IW'(idx)];
      end else begin
        tgt_ok[k]   = 1'b0;
        tgt_vals[k] = '0;
      end
    end
  end

  // R1: write pointer always addresses a real slot
  a_r1_wptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wptr_q) < N);
endmodule

// File: rtl/lg_rank_counter.sv
module lg_rank_counter
  import lg_pkg::*;
#(
  parameter int N  = 32,
  parameter int W  = 12,
  parameter int M  = 8,
  parameter int IW = 5,
  parameter int TW = 6,
  parameter int CW = 5,
  parameter int LW = 3,
  parameter int PW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] src_val,
  input  logic signed [W-1:0] tgt_vals [M],
  input  logic [M-1:0]        tgt_ok,
  input  logic                fifo_full,
  output logic                busy,
  output logic [IW-1:0]       src,
  output logic [TW-1:0]       tgt,
  output logic                push,
  output logic [CW-1:0]       push_gray,
  output logic [LW-1:0]       push_len
);
  logic          busy_q;
  logic [IW-1:0] src_q;
  logic [TW-1:0] tgt_q;
  logic [CW-1:0] cnt_q;
  logic [M-1:0]  hit;
  logic [PW-1:0] hits_n;
  logic [CW-1:0] sum;
  logic          last_chunk;
  logic          last_src;

  // parallel comparators: target strictly smaller than source
  for (genvar k = 0; k < M; k++) begin : g_cmp
    assign hit[k] = tgt_ok[k] && (tgt_vals[k] < src_val);
  end

  always_comb begin
    hits_n = '0;
    for (int k = 0; k < M; k++) hits_n = hits_n + PW'(hit[k]);
  end

  assign sum        = cnt_q + CW'(hits_n);
  assign last_chunk = (int'(tgt_q) + M) >= N;
  assign last_src   = (src_q == IW'(N - 2));
  assign push       = busy_q && last_chunk && !fifo_full;
  assign push_gray  = sum ^ (sum >> 1);
  assign push_len   = LW'(bits_for(N - int'(src_q)));
  assign busy       = busy_q;
  assign src        = src_q;
  assign tgt        = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      src_q  <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        src_q  <= '0;
        tgt_q  <= TW'(1);
        cnt_q  <= '0;
      end
    end else if (!last_chunk) begin
      cnt_q <= sum;
      tgt_q <= tgt_q + TW'(M);
    end else if (!fifo_full) begin
      cnt_q <= '0;
      if (last_src) begin
        busy_q <= 1'b0;
      end else begin
        src_q <= src_q + IW'(1);
        tgt_q <= TW'(src_q) + TW'(2);
      end
    end
  end

  // R2: running count never exceeds the entries already swept
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) <= int'(tgt_q) - int'(src_q) - 1));
  // R2: target always lies after the source while counting
  a_r2_tgt_after_src: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(tgt_q) > int'(src_q)));
  // R4: each emitted digit advances the source by one
  a_r4_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !last_src) |=> (busy_q && src_q == $past(src_q) + IW'(1)));
  // R3: every emitted digit has a nonzero width
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_len != '0));
  // R6: a finished digit blocked by a full queue freezes the sequencer
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last_chunk && fifo_full) |=> (busy_q && $stable(src_q) && $stable(tgt_q)));
endmodule

// File: rtl/lg_digit_fifo.sv
module lg_digit_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          full,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= (int'(wp_q) == DEPTH - 1) ? '0 : wp_q + AW'(1);
      if (pop)  rp_q <= (int'(rp_q) == DEPTH - 1) ? '0 : rp_q + AW'(1);
      if (push && !pop)      cnt_q <= cnt_q + (AW+1)'(1);
      else if (pop && !push) cnt_q <= cnt_q - (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  // R6: no digit is written into a full queue
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6: no digit is read from an empty queue
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lg_bit_serializer.sv
module lg_bit_serializer #(
  parameter int CW = 5,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty,
  input  logic [CW-1:0] fifo_gray,
  input  logic [LW-1:0] fifo_len,
  output logic          pop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit
);
  logic [CW-1:0] sh_q;
  logic [LW-1:0] rem_q;

  assign pop       = (rem_q == '0) && !fifo_empty;
  assign out_valid = (rem_q != '0);

  always_comb begin
    out_bit = 1'b0;
    for (int b = 0; b < CW; b++) begin
      if (int'(rem_q) == b + 1) out_bit = sh_q[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (pop) begin
      sh_q  <= fifo_gray;
      rem_q <= fifo_len;
    end else if (out_valid && out_ready) begin
      rem_q <= rem_q - LW'(1);
    end
  end

  // R6: an untaken bit stays put
  a_r6_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  // R3: remaining width never exceeds the digit register
  a_r3_rem_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rem_q) <= CW);
endmodule

// File: rtl/lehmer_gray_encoder.sv
module lehmer_gray_encoder #(
  parameter int N      = 32,
  parameter int W      = 12,
  parameter int M      = 8,
  parameter int FDEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         busy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_bit
);
  localparam int IW = $clog2(N);
  localparam int TW = $clog2(N + M + 1);
  localparam int CW = $clog2(N);
  localparam int LW = $clog2(CW + 1);
  localparam int PW = $clog2(M + 1);
  localparam int DW = CW + LW;

  logic                wr_en, load_last;
  logic [IW-1:0]       src;
  logic [TW-1:0]       tgt;
  logic signed [W-1:0] src_val;
  logic signed [W-1:0] tgt_vals [M];
  logic [M-1:0]        tgt_ok;
  logic                push, pop, fifo_full, fifo_empty;
  logic [CW-1:0]       push_gray, pop_gray;
  logic [LW-1:0]       push_len, pop_len;

  assign in_ready = !busy;
  assign wr_en    = in_valid && in_ready;

  lg_value_store #(.N(N), .W(W), .M(M), .IW(IW), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data($signed(in_data)),
    .src(src), .tgt(tgt), .load_last(load_last), .src_val(src_val),
    .tgt_vals(tgt_vals), .tgt_ok(tgt_ok)
  );

  lg_rank_counter #(.N(N), .W(W), .M(M), .IW(IW), .TW(TW), .CW(CW), .LW(LW), .PW(PW)) u_count (
    .clk(clk), .rst_n(rst_n), .start(load_last), .src_val(src_val),
    .tgt_vals(tgt_vals), .tgt_ok(tgt_ok), .fifo_full(fifo_full),
    .busy(busy), .src(src), .tgt(tgt), .push(push),
    .push_gray(push_gray), .push_len(push_len)
  );

  lg_digit_fifo #(.DW(DW), .DEPTH(FDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din({push_gray, push_len}),
    .full(fifo_full), .pop(pop), .dout({pop_gray, pop_len}), .empty(fifo_empty)
  );

  lg_bit_serializer #(.CW(CW), .LW(LW)) u_ser (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_gray(pop_gray),
    .fifo_len(pop_len), .pop(pop), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit)
  );

  // R1: accepting the last value of a block starts the count
  a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_last |=> busy);
  // R7: reset leaves the block idle
  a_r7_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!busy && !out_valid));
endmodule

// File: tb/sim_lehmer_gray_encoder.sv
module sim_lehmer_gray_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int W = 12;
  localparam int M = 8;
  localparam int NOMINAL = 76;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ready = 1'b0;
  wire  in_ready, busy, out_valid, out_bit;

  int checks = 0;
  int fails  = 0;
  int rmode  = 0;       // 0 always ready, 1 irregular, 2 never
  int exp_q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 1'b0;
  logic prev_bit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lehmer_gray_encoder #(.N(N), .W(W), .M(M), .FDEPTH(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int clog2i(input int v);
    int r = 0;
    for (int k = 0; k < 31; k++) if ((1 << k) < v) r = k + 1;
    return r;
  endfunction

  // independent model: Lehmer digits, Gray code, MSB first
  task automatic model_block(input int v[N]);
    for (int i = 0; i < N - 1; i++) begin
      int d = 0;
      int g, len;
      for (int j = i + 1; j < N; j++) if (v[j] < v[i]) d++;
      g = d ^ (d >> 1);
      len = clog2i(N - i);
      for (int b = len - 1; b >= 0; b--) exp_q.push_back((g >> b) & 1);
    end
  endtask

  // output consumer and stream checker
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && out_valid)
        check(out_bit == prev_bit, "R6 held bit", int'(out_bit), int'(prev_bit));
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[0] | lfsr[3];
        default: out_ready = 1'b0;
      endcase
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 extra bit", int'(out_bit), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(out_bit) == e, "R3/R4 stream bit", int'(out_bit), e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
    end
  end

  task automatic load_block(input int v[N]);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(v[i]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    int t = 0;
    while ((exp_q.size() != 0 || out_valid || busy) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 in_ready", int'(in_ready), 1);
    check(busy == 1'b0, "R7 busy", int'(busy), 0);
    check(out_valid == 1'b0, "R7 out_valid", int'(out_valid), 0);
  endtask

  // ascending values: all digits 0; also count time
  task automatic t_ascending;
    int v[N];
    int n = 0;
    rmode = 0;
    for (int i = 0; i < N; i++) v[i] = i - 10;
    model_block(v);
    check(exp_q.size() == 129, "R3 bit total", exp_q.size(), 129);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(v[i]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(busy == 1'b1, "R1 busy after last", int'(busy), 1);
    check(in_ready == 1'b0, "R1 in_ready while busy", int'(in_ready), 0);
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check(n == NOMINAL, "R5 count cycles", n, NOMINAL);
    wait_drain("R2 ascending drain");
  endtask

  // descending: digit i = N-1-i
  task automatic t_descending;
    int v[N];
    rmode = 0;
    for (int i = 0; i < N; i++) v[i] = 100 - 3 * i;
    model_block(v);
    load_block(v);
    wait_drain("R2 descending drain");
  endtask

  // signed and tied values
  task automatic t_signed_ties;
    int v[N];
    rmode = 1;
    for (int i = 0; i < N; i++) v[i] = ((i * 7) % 5) - 2;
    v[0] = -2048; v[1] = 2047; v[2] = -1; v[3] = 0; v[4] = -1;
    model_block(v);
    load_block(v);
    wait_drain("R2 signed ties drain");
  endtask

  // two blocks with output blocked: queue fills, sequencer stalls
  task automatic t_stall_two_blocks;
    int a[N];
    int b[N];
    logic [11:0] x = 12'h5A3;
    rmode = 2;
    for (int i = 0; i < N; i++) begin
      x = {x[10:0], x[11] ^ x[10] ^ x[9] ^ x[3]};
      a[i] = int'($signed(x));
      b[i] = int'($signed(x ^ 12'h0F0));
    end
    model_block(a);
    model_block(b);
    load_block(a);
    load_block(b);
    repeat (NOMINAL + 60) @(negedge clk);
    check(busy == 1'b1, "R6 stall keeps busy", int'(busy), 1);
    check(in_ready == 1'b0, "R6 no load during stall", int'(in_ready), 0);
    rmode = 1;
    wait_drain("R8 back-to-back drain");
  endtask

  // load next block while previous bits still draining
  task automatic t_overlap;
    int a[N];
    int b[N];
    rmode = 1;
    for (int i = 0; i < N; i++) begin
      a[i] = (i * 13) % 31 - 15;
      b[i] = (i * 19) % 29 - 14;
    end
    model_block(a);
    model_block(b);
    load_block(a);
    load_block(b);
    wait_drain("R8 overlap drain");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ascending();
    t_descending();
    t_signed_ties();
    t_stall_two_blocks();
    t_overlap();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule